// File: doc/BRIEF.md
# Power Fault Retry Supervisor

This block controls the enable of a USB Type-C power port. It watches four digital fault flags that come from comparators outside the block: overvoltage, undervoltage, overcurrent and overtemperature. Each flag only counts as a fault if it applies to the port's current power role and contract state. When a counted fault arrives, the port enable drops and a programmable off time starts. The off time is measured in strobes of an external 1 ms tick. When it ends, the port is enabled again. If the fault is still there, the cycle repeats.

A programmable limit sets how many re-enable attempts are allowed. Once the limit is used up, the next fault switches the port off and keeps it off. Only two things release this latched state: a synchronous hard reset, or the partner detaching and then attaching again. A cause code output records the first fault of the current episode. An episode ends when the port has run fault-free for one full off period. At that point the retry count and the cause code both return to zero.

The fault flags are asynchronous and pass through two flip-flops before use. The role, contract, attach and tick inputs are assumed to be synchronous to `clk`. `tick_ms` is a single-cycle strobe.

Top module: `pfault_supervisor`

## Requirements
- R1: After reset, `port_en`, `latched_off` and `fault_code` are all 0. The port stays disabled while detached. Raising `attached` (with no latch pending) sets `port_en` to 1 one clock edge later.
- R2: Each fault flag passes through a two-flop synchronizer. A flag raised before clock edge n is first acted on at edge n+2. `port_en` still reads 1 after edges n and n+1 and reads 0 after edge n+2.
- R3: Overvoltage (`flt_ov`, cause code 1) counts in both roles, but only while `contract_ok` is 1.
- R4: Undervoltage (`flt_uv`, cause code 2) counts only when `role_src` is 1 (source role) and `contract_ok` is 1.
- R5: Overcurrent (`flt_oc`, cause code 3) counts only when `role_src` is 1, whatever the value of `contract_ok`.
- R6: Overtemperature (`flt_ot`, cause code 4) counts in both roles and in every contract state.
- R7: After a counted fault, the port stays disabled through exactly max(`cfg_off_ticks`,1) tick strobes. It reads enabled right after the edge that captures the last strobe. Fault flags are ignored while the port is off.
- R8: With `cfg_retry_max` = N, an episode allows N re-enables. The (N+1)th counted fault sets `latched_off` to 1 and holds `port_en` at 0. Further faults and ticks then have no effect.
- R9: While `attached` is 0, the state is cleared: `latched_off`, `fault_code` and the retry count return to 0. A later attach enables the port again. A hard reset also clears the latch.
- R10: After a re-enable, if the port then sees max(`cfg_off_ticks`,1) tick strobes with no counted fault, the episode ends. `fault_code` returns to 0 and the full retry allowance is restored.
- R11: `fault_code` holds the cause of the first counted fault of the episode, coded 0 none, 1 OV, 2 UV, 3 OC, 4 OT. If several faults count at the same time, the lowest code wins. Later faults in the same episode do not change the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hard reset |
| flt_ov | input | 1 | Overvoltage comparator flag (asynchronous) |
| flt_uv | input | 1 | Undervoltage comparator flag (asynchronous) |
| flt_oc | input | 1 | Overcurrent comparator flag (asynchronous) |
| flt_ot | input | 1 | Overtemperature flag (asynchronous) |
| role_src | input | 1 | 1 = source role, 0 = sink role |
| contract_ok | input | 1 | 1 once a power contract has been negotiated |
| attached | input | 1 | 1 while a partner is attached |
| tick_ms | input | 1 | One-cycle strobe every millisecond |
| cfg_off_ticks | input | TICK_W | Off time in tick strobes (0 behaves as 1) |
| cfg_retry_max | input | RETRY_W | Re-enables allowed per episode |
| port_en | output | 1 | Port power enable |
| latched_off | output | 1 | Port latched off after the retries are used up |
| fault_code | output | 3 | First fault cause of the current episode |

## Verification
The hardest state to reach from the ports is the end of an episode after a partial retry history. The port has to be re-enabled with a nonzero retry count, then see exactly the off period of ticks with no fault, and only then face a new fault. The bench releases the fault while the port is off and waits out the synchronizer delay. It then steps the tick strobe one pulse at a time to land one tick short of the episode end and exactly on it. The test ends with a fresh fault, and the bench checks whether that fault latches or retries. A sweep over every off time from 0 to 3 and retry limit from 0 to 2 holds a persistent fault and counts the re-enables arithmetically. A second sweep covers all four flags under both roles and both contract states.

// File: rtl/pfs_pkg.sv
// Shared types for the power fault retry supervisor.
// Fault vector bit order also sets cause priority: lower index wins.
package pfs_pkg;
    localparam int unsigned FLT_N  = 4;
    localparam int unsigned IDX_OV = 0;
    localparam int unsigned IDX_UV = 1;
    localparam int unsigned IDX_OC = 2;
    localparam int unsigned IDX_OT = 3;

    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_OV   = 3'd1,
        CAUSE_UV   = 3'd2,
        CAUSE_OC   = 3'd3,
        CAUSE_OT   = 3'd4
    } cause_t;

    typedef enum logic [1:0] {
        ST_DET   = 2'd0,
        ST_RUN   = 2'd1,
        ST_OFF   = 2'd2,
        ST_LATCH = 2'd3
    } state_t;
endpackage

// File: rtl/pfs_sync.sv
// Multi-stage flip-flop synchronizer for a vector of asynchronous flags.
// Assumes each bit is an independent level; no bus coherency is implied.
module pfs_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage samples the raw flags.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_async;
    end

    // Remaining stages shift the sample along the chain.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/pfs_qual.sv
// Fault qualification: masks each synchronized flag by role and contract
// state, then picks the highest-priority qualified cause.
// Assumes role_src and contract_ok are synchronous to clk.
module pfs_qual
    import pfs_pkg::*;
(
    input  logic [FLT_N-1:0] flt_sync,
    input  logic             role_src,
    input  logic             contract_ok,
    output logic             qual_any,
    output cause_t           qual_code
);
    logic [FLT_N-1:0] enable_mask;
    logic [FLT_N-1:0] qual_vec;

    // Per-fault enable: voltage faults need a contract, UV/OC need source role.
    always_comb begin
        enable_mask         = '0;
        enable_mask[IDX_OV] = contract_ok;
        enable_mask[IDX_UV] = role_src & contract_ok;
        enable_mask[IDX_OC] = role_src;
        enable_mask[IDX_OT] = 1'b1;
    end

    assign qual_vec = flt_sync & enable_mask;
    assign qual_any = |qual_vec;

    // Priority encode: scan from lowest priority up so the lowest index wins.
    always_comb begin
        qual_code = CAUSE_NONE;
        for (int i = FLT_N - 1; i >= 0; i--) begin
            if (qual_vec[i]) qual_code = cause_t'(3'(i + 1));
        end
    end
endmodule

// File: rtl/pfs_ctrl.sv
// Retry controller: disables the port on a qualified fault, times the off
// period in tick strobes, counts retries and latches off when they run out.
// Assumes attached and tick_ms are synchronous; tick_ms is a 1-cycle strobe.
module pfs_ctrl
    import pfs_pkg::*;
#(
    parameter int unsigned TICK_W  = 8,
    parameter int unsigned RETRY_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               attached,
    input  logic               tick_ms,
    input  logic               qual_any,
    input  cause_t             qual_code,
    input  logic [TICK_W-1:0]  cfg_off_ticks,
    input  logic [RETRY_W-1:0] cfg_retry_max,
    output logic               port_en,
    output logic               latched_off,
    output cause_t             fault_code
);
    localparam int unsigned TW1 = TICK_W + 1;

    state_t             state_q, state_d;
    logic [TICK_W-1:0]  timer_q, timer_d;
    logic [RETRY_W-1:0] retry_q, retry_d;
    cause_t             cause_q, cause_d;
    logic [TW1-1:0]     timer_inc;
    logic               period_end;

    // Tick count after this strobe, compared against the programmed period.
    assign timer_inc  = {1'b0, timer_q} + {{TICK_W{1'b0}}, 1'b1};
    assign period_end = tick_ms && (timer_inc >= {1'b0, cfg_off_ticks});

    // Next-state logic; detach overrides every state.
    always_comb begin
        state_d = state_q;
        timer_d = timer_q;
        retry_d = retry_q;
        cause_d = cause_q;
        if (!attached) begin
            state_d = ST_DET;
            timer_d = '0;
            retry_d = '0;
            cause_d = CAUSE_NONE;
        end else begin
            case (state_q)
                ST_DET: begin
                    state_d = ST_RUN;
                    timer_d = '0;
                end
                ST_RUN: begin
                    if (qual_any) begin
                        timer_d = '0;
                        if (cause_q == CAUSE_NONE) cause_d = qual_code;
                        if (retry_q >= cfg_retry_max) begin
                            state_d = ST_LATCH;
                        end else begin
                            state_d = ST_OFF;
                            retry_d = retry_q + 1'b1;
                        end
                    end else if (tick_ms) begin
                        if (period_end) begin
                            timer_d = '0;
                            retry_d = '0;
                            cause_d = CAUSE_NONE;
                        end else begin
                            timer_d = timer_inc[TICK_W-1:0];
                        end
                    end
                end
                ST_OFF: begin
                    if (tick_ms) begin
                        if (period_end) begin
                            state_d = ST_RUN;
                            timer_d = '0;
                        end else begin
                            timer_d = timer_inc[TICK_W-1:0];
                        end
                    end
                end
                default: begin
                    state_d = ST_LATCH;
                end
            endcase
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_DET;
            timer_q <= '0;
            retry_q <= '0;
            cause_q <= CAUSE_NONE;
        end else begin
            state_q <= state_d;
            timer_q <= timer_d;
            retry_q <= retry_d;
            cause_q <= cause_d;
        end
    end

    assign port_en     = (state_q == ST_RUN);
    assign latched_off = (state_q == ST_LATCH);
    assign fault_code  = cause_q;

    // The off period only ends on a tick strobe.
    assert_off_needs_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF && attached && !tick_ms) |=> (state_q == ST_OFF));

    // Once latched, only a detach or reset leaves the state.
    assert_latch_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH && attached) |=> (state_q == ST_LATCH));

    // Being in the off period means at least one retry has been spent.
    assert_off_has_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |-> (retry_q != '0));

    // A detach clears latch, retry count and cause on the next edge.
    assert_detach_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !attached |=> (state_q == ST_DET && retry_q == '0 && cause_q == CAUSE_NONE));

    // A qualified fault while running always leaves a recorded cause.
    assert_fault_records_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && attached && qual_any) |=> (cause_q != CAUSE_NONE));
endmodule

// File: rtl/pfault_supervisor.sv
// Top of the power fault retry supervisor: synchronizes the fault flags,
// qualifies them by role and contract, and drives the retry controller.
// Assumes all non-fault inputs are synchronous to clk.
module pfault_supervisor
    import pfs_pkg::*;
#(
    parameter int unsigned TICK_W  = 8,
    parameter int unsigned RETRY_W = 3,
    parameter int unsigned SYNC_N  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flt_ov,
    input  logic               flt_uv,
    input  logic               flt_oc,
    input  logic               flt_ot,
    input  logic               role_src,
    input  logic               contract_ok,
    input  logic               attached,
    input  logic               tick_ms,
    input  logic [TICK_W-1:0]  cfg_off_ticks,
    input  logic [RETRY_W-1:0] cfg_retry_max,
    output logic               port_en,
    output logic               latched_off,
    output logic [2:0]         fault_code
);
    logic [FLT_N-1:0] flt_raw;
    logic [FLT_N-1:0] flt_sync;
    logic             qual_any;
    cause_t           qual_code;
    cause_t           cause;

    // Pack the raw flags in priority order.
    always_comb begin
        flt_raw         = '0;
        flt_raw[IDX_OV] = flt_ov;
        flt_raw[IDX_UV] = flt_uv;
        flt_raw[IDX_OC] = flt_oc;
        flt_raw[IDX_OT] = flt_ot;
    end

    pfs_sync #(.WIDTH(FLT_N), .STAGES(SYNC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (flt_raw),
        .q_sync  (flt_sync)
    );

    pfs_qual u_qual (
        .flt_sync    (flt_sync),
        .role_src    (role_src),
        .contract_ok (contract_ok),
        .qual_any    (qual_any),
        .qual_code   (qual_code)
    );

    pfs_ctrl #(.TICK_W(TICK_W), .RETRY_W(RETRY_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .attached      (attached),
        .tick_ms       (tick_ms),
        .qual_any      (qual_any),
        .qual_code     (qual_code),
        .cfg_off_ticks (cfg_off_ticks),
        .cfg_retry_max (cfg_retry_max),
        .port_en       (port_en),
        .latched_off   (latched_off),
        .fault_code    (cause)
    );

    assign fault_code = cause;

    // A running port is never reported as latched.
    assert_en_not_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        port_en |-> !latched_off);

    // The port can only fall while attached if the qualifier saw a fault.
    assert_drop_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(port_en) && $past(attached)) |-> $past(qual_any));
endmodule

// File: tb/pfault_supervisor_tb_top.sv
// Self-checking bench: sweeps fault qualification and retry configurations.
module pfault_supervisor_tb_top;
    localparam int TW = 8;
    localparam int RW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [3:0]    flt;
    logic          role_src, contract_ok, attached, tick_ms;
    logic [TW-1:0] cfg_off;
    logic [RW-1:0] cfg_rmax;
    logic          port_en, latched_off;
    logic [2:0]    fault_code;
    int            checks = 0;
    int            errors = 0;
    bit            done   = 1'b0;

    always #5 clk = ~clk;

    pfault_supervisor #(.TICK_W(TW), .RETRY_W(RW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .flt_ov(flt[0]), .flt_uv(flt[1]), .flt_oc(flt[2]), .flt_ot(flt[3]),
        .role_src(role_src), .contract_ok(contract_ok), .attached(attached),
        .tick_ms(tick_ms), .cfg_off_ticks(cfg_off), .cfg_retry_max(cfg_rmax),
        .port_en(port_en), .latched_off(latched_off), .fault_code(fault_code)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        tick_ms = 1'b1;
        step(1);
        tick_ms = 1'b0;
    endtask

    task automatic hard_reset();
        rst_n = 1'b0; attached = 1'b0; flt = '0; tick_ms = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic attach_now();
        attached = 1'b1;
        step(1);
    endtask

    task automatic detach_now();
        flt = '0;
        attached = 1'b0;
        step(3);
    endtask

    initial begin
        fork
            begin
                #(200000 * 10);
                if (!done) begin
                    errors++;
                    checks++;
                    $display("FAIL watchdog actual=1 expected=0");
                    $display("CHECKS %0d ERRORS %0d", checks, errors);
                    $finish;
                end
            end
        join_none
    end

    initial begin
        rst_n = 1'b0; flt = '0; role_src = 1'b0; contract_ok = 1'b0;
        attached = 1'b0; tick_ms = 1'b0; cfg_off = 8'd2; cfg_rmax = 3'd3;

        // R1: reset state and attach
        hard_reset();
        check("R1 reset en", int'(port_en), 0);
        check("R1 reset latched", int'(latched_off), 0);
        check("R1 reset code", int'(fault_code), 0);
        step(2);
        check("R1 detached en", int'(port_en), 0);
        attach_now();
        check("R1 attach en", int'(port_en), 1);

        // R2: two-flop synchronizer latency
        flt[3] = 1'b1;
        step(1);
        check("R2 after edge n", int'(port_en), 1);
        step(1);
        check("R2 after edge n+1", int'(port_en), 1);
        step(1);
        check("R2 after edge n+2", int'(port_en), 0);
        detach_now();

        // R3 R4 R5 R6: qualification sweep over fault, role and contract
        for (int f = 0; f < 4; f++) begin
            for (int src = 0; src < 2; src++) begin
                for (int ct = 0; ct < 2; ct++) begin
                    bit q;
                    string tag;
                    q = (f == 0) ? bit'(ct) :
                        (f == 1) ? bit'(src & ct) :
                        (f == 2) ? bit'(src) : 1'b1;
                    tag = (f == 0) ? "R3" : (f == 1) ? "R4" : (f == 2) ? "R5" : "R6";
                    role_src = 1'(src); contract_ok = 1'(ct);
                    cfg_rmax = 3'd3; cfg_off = 8'd2;
                    attach_now();
                    flt[f] = 1'b1;
                    step(3);
                    check($sformatf("%s qual en f%0d s%0d c%0d", tag, f, src, ct),
                          int'(port_en), q ? 0 : 1);
                    check($sformatf("%s qual code f%0d s%0d c%0d", tag, f, src, ct),
                          int'(fault_code), q ? f + 1 : 0);
                    detach_now();
                end
            end
        end

        // R7 R8 R9: persistent fault over off time 0..3 and retry limit 0..2
        for (int off = 0; off < 4; off++) begin
            for (int rm = 0; rm < 3; rm++) begin
                int eff;
                eff = (off == 0) ? 1 : off;
                role_src = 1'b0; contract_ok = 1'b0;
                cfg_off = 8'(off); cfg_rmax = 3'(rm);
                attach_now();
                flt[3] = 1'b1;
                step(3);
                for (int k = 0; k <= rm; k++) begin
                    if (k < rm) begin
                        check($sformatf("R8 retry off o%0d r%0d k%0d", off, rm, k),
                              int'(latched_off), 0);
                        for (int t = 0; t < eff - 1; t++) tick();
                        check($sformatf("R7 still off o%0d r%0d k%0d", off, rm, k),
                              int'(port_en), 0);
                        tick();
                        check($sformatf("R7 reenable o%0d r%0d k%0d", off, rm, k),
                              int'(port_en), 1);
                        step(1);
                    end else begin
                        check($sformatf("R8 latched o%0d r%0d", off, rm),
                              int'(latched_off), 1);
                    end
                end
                for (int t = 0; t < 5; t++) tick();
                check($sformatf("R8 latch ignores ticks o%0d r%0d", off, rm),
                      int'(port_en), 0);
                check($sformatf("R11 code kept o%0d r%0d", off, rm), int'(fault_code), 4);
                detach_now();
                check($sformatf("R9 detach latch o%0d r%0d", off, rm), int'(latched_off), 0);
                check($sformatf("R9 detach code o%0d r%0d", off, rm), int'(fault_code), 0);
                attach_now();
                check($sformatf("R9 reattach en o%0d r%0d", off, rm), int'(port_en), 1);
                attached = 1'b0;
                step(2);
            end
        end

        // R7: faults during off period are ignored; R10: episode end
        role_src = 1'b1; contract_ok = 1'b1; cfg_off = 8'd2; cfg_rmax = 3'd1;
        attach_now();
        flt[3] = 1'b1;
        step(3);
        flt[3] = 1'b0;
        flt[0] = 1'b1;
        step(3);
        flt[0] = 1'b0;
        step(3);
        check("R7 off ignores new fault code", int'(fault_code), 4);
        tick(); tick();
        check("R10 reenabled", int'(port_en), 1);
        tick();
        check("R10 one tick short code", int'(fault_code), 4);
        tick();
        check("R10 episode end code", int'(fault_code), 0);
        flt[2] = 1'b1;
        step(3);
        check("R10 allowance restored latched", int'(latched_off), 0);
        check("R10 allowance restored en", int'(port_en), 0);
        check("R11 new episode code", int'(fault_code), 3);
        flt[2] = 1'b0;
        step(3);
        tick(); tick();
        tick();
        flt[2] = 1'b1;
        step(3);
        check("R10 partial period latches", int'(latched_off), 1);

        // R9: hard reset clears the latch
        hard_reset();
        check("R9 hard reset latch", int'(latched_off), 0);
        check("R9 hard reset code", int'(fault_code), 0);

        // R11: priority and first-cause retention
        cfg_rmax = 3'd2; cfg_off = 8'd1;
        attach_now();
        flt = 4'b1001;
        step(3);
        check("R11 OV beats OT", int'(fault_code), 1);
        flt = 4'b1000;
        step(3);
        tick();
        step(1);
        check("R11 first cause held", int'(fault_code), 1);
        detach_now();
        attach_now();
        flt = 4'b0110;
        step(3);
        check("R11 UV beats OC", int'(fault_code), 2);
        detach_now();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule